// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the stream of column addresses a synchronous DRAM burst walks through, one address per clock. A request is a one-cycle start pulse carrying an 8-bit start column, a 3-bit length code and an ordering select. The ordering is either sequential or interleaved. In sequential order the low bits count up and wrap inside the aligned burst window. In interleaved order the low bits of the start column are XORed with the beat number.

The burst runs for 1, 2, 4 or 8 beats. In sequential order it can also run as an open-ended full-page burst that wraps around the whole 256-column row. A new start is accepted on any clock and replaces whatever is still running. A stop input ends a burst early. A length request that cannot be honoured is reported as an error and shortened to a single beat.

The block sits between a command sequencer, which issues start and stop, and the address multiplexer that drives the column lines.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `valid_o`, `last_o` and `err_o` are low and `col_o` is 0.
- R2: A start sampled at a rising edge makes `valid_o` high after that edge, with `col_o` equal to the sampled start column (beat 0).
- R3: With `ilv_i`=0 and a fixed length of BL beats, beat n has the start column's bits above log2(BL) unchanged, and its low log2(BL) bits equal to (start low bits + n) mod BL.
- R4: With `ilv_i`=1, beat n has the start column's low log2(BL) bits XORed with n, and the upper bits unchanged.
- R5: Length codes are 0→1, 1→2, 2→4, 3→8 beats and 7→full page. For a fixed length, `last_o` is high with the final beat only, and `valid_o` drops after it unless a new start is sampled.
- R6: Code 7 with `ilv_i`=0 gives a full-page burst. Its address is start+n mod 256, it never raises `last_o`, and it runs until a stop or a new start.
- R7: Code 7 with `ilv_i`=1, or any of codes 4, 5 and 6, raises `err_o` with beat 0 only. The burst is then one beat long, so `last_o` is high on that beat.
- R8: A start sampled during a burst replaces it. The next cycle shows beat 0 of the new burst, with its own length and order.
- R9: `stop_i` during a burst makes `valid_o` low after the edge. Stop has no effect when a start is sampled in the same cycle, and none while idle.
- R10: `last_o` and `err_o` are never high while `valid_o` is low, and `col_o` is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst this cycle |
| start_col_i | input | 8 | Start column sampled with `start_i` |
| blen_i | input | 3 | Length code sampled with `start_i` |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | End the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Rejected length code, shown with beat 0 |

## Verification
Three situations are hard to reach from the ports. The first is the wrap of a full-page burst past column 255. The second is a start or stop landing on exactly the beat that carries `last_o`. The third is a start and a stop in the same cycle. Directed sequences start a full-page burst at column 0xFE and issue a start and a stop together. Long random runs, with frequent starts and occasional stops, let new requests and stops fall on every beat position, including the last beat of all four fixed lengths in both orders.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    // length codes accepted on blen_i
    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    // beat ordering inside the burst window
    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W       = 8,
    parameter int CODE_W      = 3,
    parameter int FULL_CODE   = 7,
    parameter int MAX_FIX_LOG = 3
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              ilv_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_o,
    output logic              err_o
);
    localparam int NB_W = $clog2(COL_W + 1);

    logic [NB_W-1:0] nbits;

    always_comb begin
        nbits  = '0;
        full_o = 1'b0;
        err_o  = 1'b0;
        if (code_i == CODE_W'(FULL_CODE)) begin
            if (ilv_i) begin
                err_o = 1'b1;
            end else begin
                full_o = 1'b1;
                nbits  = NB_W'(COL_W);
            end
        end else if (int'(code_i) <= MAX_FIX_LOG) begin
            nbits = NB_W'(code_i);
        end else begin
            err_o = 1'b1;
        end
    end

    // one mask bit per column bit: set for bits that move inside the burst
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = (nbits > NB_W'(i));
    end

endmodule

// File: rtl/bcg_addr_form.sv
module bcg_addr_form #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_mix;
    logic [COL_W-1:0] pick;

    always_comb begin
        seq_sum = base_i + beat_i;
        ilv_mix = base_i ^ beat_i;
        pick    = ilv_i ? ilv_mix : seq_sum;
    end

    // moving bits come from the ordering result, fixed bits from the base
    for (genvar i = 0; i < COL_W; i++) begin : g_merge
        assign col_o[i] = mask_i[i] ? pick[i] : base_i[i];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W       = 8,
    parameter int CODE_W      = 3,
    parameter int FULL_CODE   = 7,
    parameter int MAX_FIX_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] blen_i,
    input  logic              ilv_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              err_o
);
    import bcg_pkg::*;

    typedef struct packed {
        logic             act;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        order_e           ord;
        logic             full;
        logic             err;
    } burst_st_t;

    burst_st_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_err;
    logic [COL_W-1:0] formed_col;
    logic             at_last;

    bcg_len_decode #(
        .COL_W      (COL_W),
        .CODE_W     (CODE_W),
        .FULL_CODE  (FULL_CODE),
        .MAX_FIX_LOG(MAX_FIX_LOG)
    ) u_dec (
        .code_i (blen_i),
        .ilv_i  (ilv_i),
        .mask_o (dec_mask),
        .full_o (dec_full),
        .err_o  (dec_err)
    );

    bcg_addr_form #(
        .COL_W(COL_W)
    ) u_form (
        .base_i (st_q.base),
        .beat_i (st_q.beat),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ord == ORD_ILV),
        .col_o  (formed_col)
    );

    assign at_last = st_q.act && !st_q.full && (st_q.beat == st_q.mask);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (start_i) begin
            st_d.act  = 1'b1;
            st_d.base = start_col_i;
            st_d.beat = '0;
            st_d.mask = dec_mask;
            st_d.ord  = ilv_i ? ORD_ILV : ORD_SEQ;
            st_d.full = dec_full;
            st_d.err  = dec_err;
        end else if (st_q.act) begin
            if (stop_i || at_last) begin
                st_d.act = 1'b0;
            end else begin
                st_d.beat = st_q.beat + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.act;
    assign last_o  = at_last;
    assign err_o   = st_q.act && st_q.err;
    assign col_o   = st_q.act ? formed_col : '0;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W     = 8,
    parameter int CODE_W    = 3,
    parameter int FULL_CODE = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [CODE_W-1:0] blen_i,
    input logic              ilv_i,
    input logic              stop_i,
    input logic [COL_W-1:0]  col_o,
    input logic              valid_o,
    input logic              last_o,
    input logic              err_o
);
    logic bad_len;
    assign bad_len = (blen_i == CODE_W'(FULL_CODE)) ? ilv_i : (int'(blen_i) > 3);

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !valid_o |=> valid_o && col_o == $past(start_col_i));

    assert_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && valid_o |=> valid_o && col_o == $past(start_col_i));

    assert_bad_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && bad_len |=> err_o && last_o);

    assert_end_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !valid_o);

    assert_runs_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o && !start_i && !stop_i |=> valid_o);

    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && stop_i && !start_i |=> !valid_o);

    assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !last_o && !err_o && col_o == '0);

endmodule

bind burst_col_gen bcg_checker #(
    .COL_W    (COL_W),
    .CODE_W   (CODE_W),
    .FULL_CODE(FULL_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .blen_i     (blen_i),
    .ilv_i      (ilv_i),
    .stop_i     (stop_i),
    .col_o      (col_o),
    .valid_o    (valid_o),
    .last_o     (last_o),
    .err_o      (err_o)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o, last_o, err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state derived from the requirements
    bit       m_act = 0;
    int       m_base = 0, m_beat = 0, m_bl = 1;
    bit       m_full = 0, m_ilv = 0, m_err = 0;

    always #4 clk = ~clk;

    burst_col_gen u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    function automatic int exp_col();
        int mask = m_bl - 1;
        int mov;
        if (!m_act) return 0;
        if (m_full) return (m_base + m_beat) & 255;
        mov = m_ilv ? (m_base ^ m_beat) : (m_base + m_beat);
        return (m_base & ~mask & 255) | (mov & mask);
    endfunction

    function automatic bit exp_last();
        return m_act && !m_full && (m_beat == m_bl - 1);
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_act = 0; m_err = 0;
        end else if (start_i) begin
            m_act = 1; m_base = int'(start_col_i); m_beat = 0;
            m_ilv = ilv_i; m_full = 0; m_err = 0;
            if (blen_i <= 3) m_bl = 1 << blen_i;
            else if (blen_i == 7 && !ilv_i) begin m_full = 1; m_bl = 256; end
            else begin m_bl = 1; m_err = 1; end
        end else begin
            m_err = 0;
            if (m_act) begin
                if (stop_i || exp_last()) m_act = 0;
                else m_beat = (m_beat + 1) & 255;
            end
        end
    endtask

    task automatic check_vec(input string tag);
        int  ec = exp_col();
        bit  el = exp_last();
        bit  ee = m_act && m_err;
        n_vec++;
        if (valid_o !== m_act || last_o !== el || err_o !== ee || int'(col_o) != ec) begin
            n_bad++;
            $display("FAIL %s: col/valid/last/err actual %02h/%0b/%0b/%0b expected %02h/%0b/%0b/%0b",
                     tag, col_o, valid_o, last_o, err_o, ec[7:0], m_act, el, ee);
        end
    endtask

    function automatic string auto_tag();
        if (!m_act) return "R10";
        if (m_err) return "R7";
        if (m_full) return "R6";
        if (m_ilv) return "R4";
        return "R3";
    endfunction

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit st, input int col, input int code, input bit il,
                       input bit sp, input string tag);
        start_i = st; start_col_i = col[7:0]; blen_i = code[2:0];
        ilv_i = il; stop_i = sp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_vec(tag == "" ? auto_tag() : tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        idle(3, "R1");
        rst_n = 1'b1;
        idle(1, "R1");

        // R2 R3 R5: sequential 8 beats from 0x2D -> 2D 2E 2F 28 29 2A 2B 2C
        cyc(1, 8'h2D, 3, 0, 0, "R2");
        idle(8, "R5");
        // R4: interleaved 4 beats from 0x56 -> 56 57 54 55
        cyc(1, 8'h56, 2, 1, 0, "R4");
        idle(4, "R4");
        // R5: single beat, then 2-beat sequential from odd column
        cyc(1, 8'h11, 0, 0, 0, "R5");
        idle(1, "R5");
        cyc(1, 8'h33, 1, 0, 0, "R5");
        idle(2, "R5");
        // R6 R9: full page from 0xFE wraps to 00, then stop
        cyc(1, 8'hFE, 7, 0, 0, "R6");
        idle(5, "R6");
        cyc(0, 0, 0, 0, 1, "R9");
        idle(1, "R9");
        // R7: full page with interleave, and a reserved code
        cyc(1, 8'h9A, 7, 1, 0, "R7");
        idle(1, "R7");
        cyc(1, 8'h44, 5, 0, 0, "R7");
        idle(1, "R7");
        // R8: pre-empt an 8-beat burst with a 2-beat interleaved one, then on its last beat
        cyc(1, 8'h80, 3, 0, 0, "R8");
        idle(2, "R8");
        cyc(1, 8'hC3, 1, 1, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        cyc(1, 8'h07, 2, 0, 0, "R8");
        // R9: start and stop together -> start wins; stop while idle is ignored
        cyc(1, 8'h20, 3, 0, 1, "R9");
        idle(8, "R9");
        cyc(0, 0, 0, 0, 1, "R9");
        cyc(0, 0, 0, 0, 1, "R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit st = ($urandom_range(0, 5) == 0);
            bit sp = ($urandom_range(0, 19) == 0);
            int cd = (i % 3 == 0) ? ($urandom_range(0, 1) ? 7 : $urandom_range(0, 3))
                                  : $urandom_range(0, 7);
            cyc(st, $urandom_range(0, 255), cd, 1'($urandom_range(0, 1)), sp, "");
        end

        // reset in the middle of a burst returns outputs to idle
        cyc(1, 8'h5A, 7, 0, 0, "R6");
        rst_n = 1'b0;
        idle(2, "R1");
        rst_n = 1'b1;
        idle(1, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule